// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called A and B, and moves data across in either direction. Each direction has its own capture register. A select per direction chooses what goes out on the far bus: either the live value of the near bus, or the value held in that direction's register. The data path is split into byte-wide halves. Every half has its own six controls: two output enables with opposite polarity, two capture strobes and two selects. Software can drive all halves with the same controls to get one wide path.

For a synthesizable model the bidirectional pins become separate `*_in`, `*_out` and `*_oe` vectors. The surrounding logic resolves them into real buses. The capture strobes are sampled on the system clock. A register loads on the clock edge where its strobe is first seen high. It loads on every such rising strobe, whatever the enable and select levels are.

Each half decodes its two enable levels into one of four named modes. The mode is set by the enable levels alone:
- `MODE_ISOLATE`: A-to-B disabled, B-to-A disabled. Neither bus is driven.
- `MODE_A2B`: only the B bus is driven.
- `MODE_B2A`: only the A bus is driven.
- `MODE_BOTH`: both buses are driven.

The mode changes as soon as the enables change; there are no other transitions. Both directions can be enabled with both selects live. A naive model of that case would form a combinational ring. Instead, each bus is driven with a copy of the other bus's resolved value from the previous clock, so the pair keeps its last value.

Top module: `xcvr_regbus`

## Requirements
- R1: An active-low asynchronous reset clears both capture registers of every half to zero.
- R2: `b_oe` bits of a half are all 1 exactly when that half's `ab_en` is 1 (active high), otherwise all 0.
- R3: `a_oe` bits of a half are all 1 exactly when that half's `ba_en_n` is 0 (active low), otherwise all 0.
- R4: With `ab_sel`=0 (live) and only A-to-B enabled, `b_out` equals `a_in` in the same cycle; the mirror holds for `ba_sel`=0 and `a_out`.
- R5: With a select at 1 (stored), the driven bus shows that direction's capture register: `b_out` shows the A-to-B register, and `a_out` shows the B-to-A register.
- R6: A register loads its near bus on the clock edge where its strobe first reads 1. A strobe held high does not load again.
- R7: In isolation (`ab_en`=0, `ba_en_n`=1) neither bus is driven, and strobes still load both registers.
- R8: A half may be set to A-to-B only, with `ab_sel`=0, and both strobes raised together. Then the A value lands in both registers. The mirror case gives the B value in both.
- R9: With both enables active and both selects stored, the A-to-B register drives B and the B-to-A register drives A at the same time.
- R10: With both enables active and both selects live, each bus is driven with the value the other bus had one cycle earlier, so the pair holds its last value.
- R11: Each half works only from its own controls and its own byte of data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous reset, active low |
| ab_en | input | NUM_HALVES | Per-half A-to-B enable, active high |
| ba_en_n | input | NUM_HALVES | Per-half B-to-A enable, active low |
| ab_cap | input | NUM_HALVES | Per-half A-to-B capture strobe |
| ba_cap | input | NUM_HALVES | Per-half B-to-A capture strobe |
| ab_sel | input | NUM_HALVES | Per-half A-to-B select, 1 = stored, 0 = live |
| ba_sel | input | NUM_HALVES | Per-half B-to-A select, 1 = stored, 0 = live |
| a_in | input | NUM_HALVES*HALF_W | Resolved A bus value |
| b_in | input | NUM_HALVES*HALF_W | Resolved B bus value |
| a_out | output | NUM_HALVES*HALF_W | Value driven onto the A bus |
| b_out | output | NUM_HALVES*HALF_W | Value driven onto the B bus |
| a_oe | output | NUM_HALVES*HALF_W | Per-bit drive enable for the A bus |
| b_oe | output | NUM_HALVES*HALF_W | Per-bit drive enable for the B bus |

## Verification
A vector table steps one half through all four enable modes, with each mix of live and stored selects. The two registers are preloaded with distinct values, so every output shows whether it came from the live bus, the A-to-B register or the B-to-A register. Mixing a live A path with a stored B path shows the bus feedback through the outside resolver. Directed sequences then cover the following:
- loading both registers from one bus;
- a strobe held high for several cycles, with the bus changing underneath;
- loading in isolation;
- the self-holding loop mode after the outside driver goes away;
- a second half run in a different mode at the same time, to show the halves do not interact.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'd0,
        MODE_A2B     = 2'd1,
        MODE_B2A     = 2'd2,
        MODE_BOTH    = 2'd3
    } xcvr_mode_e;

    function automatic xcvr_mode_e decode_mode(input logic ab_en, input logic ba_en_n);
        xcvr_mode_e m;
        unique case ({ab_en, ba_en_n})
            2'b01:   m = MODE_ISOLATE;
            2'b11:   m = MODE_A2B;
            2'b00:   m = MODE_B2A;
            default: m = MODE_BOTH;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    logic cap_q;
    logic cap_rise;

    assign cap_rise = cap & ~cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
            q     <= '0;
        end else begin
            cap_q <= cap;
            if (cap_rise) begin
                q <= din;
            end
        end
    end

    // R6: a first-high strobe loads the bus value present at that edge
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !cap_q) |=> (q == $past(din)));

    // R6: without a fresh rising strobe the register keeps its value
    a_r6_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap && !cap_q) |=> $stable(q));

endmodule

// File: rtl/xcvr_half.sv
module xcvr_half
    import xcvr_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ab_en,
    input  logic              ba_en_n,
    input  logic              ab_cap,
    input  logic              ba_cap,
    input  logic              ab_sel,
    input  logic              ba_sel,
    input  logic [HALF_W-1:0] a_in,
    input  logic [HALF_W-1:0] b_in,
    output logic [HALF_W-1:0] a_out,
    output logic [HALF_W-1:0] b_out,
    output logic [HALF_W-1:0] a_oe,
    output logic [HALF_W-1:0] b_oe
);

    xcvr_mode_e        mode;
    logic              loop_mode;
    logic [HALF_W-1:0] st_ab;
    logic [HALF_W-1:0] st_ba;
    logic [HALF_W-1:0] hold_a;
    logic [HALF_W-1:0] hold_b;
    logic [HALF_W-1:0] b_src;
    logic [HALF_W-1:0] a_src;

    xcvr_store #(.WIDTH(HALF_W)) u_store_ab (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (ab_cap),
        .din   (a_in),
        .q     (st_ab)
    );

    xcvr_store #(.WIDTH(HALF_W)) u_store_ba (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (ba_cap),
        .din   (b_in),
        .q     (st_ba)
    );

    // retained copy of each resolved bus, used to break the live-live ring
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_a <= '0;
            hold_b <= '0;
        end else begin
            hold_a <= a_in;
            hold_b <= b_in;
        end
    end

    assign mode      = decode_mode(ab_en, ba_en_n);
    assign loop_mode = (mode == MODE_BOTH) && !ab_sel && !ba_sel;

    always_comb begin
        b_src = ab_sel ? st_ab : (loop_mode ? hold_a : a_in);
        a_src = ba_sel ? st_ba : (loop_mode ? hold_b : b_in);
    end

    always_comb begin
        a_out = '0;
        b_out = '0;
        a_oe  = '0;
        b_oe  = '0;
        unique case (mode)
            MODE_ISOLATE: begin
            end
            MODE_A2B: begin
                b_out = b_src;
                b_oe  = '1;
            end
            MODE_B2A: begin
                a_out = a_src;
                a_oe  = '1;
            end
            MODE_BOTH: begin
                b_out = b_src;
                b_oe  = '1;
                a_out = a_src;
                a_oe  = '1;
            end
            default: begin
            end
        endcase
    end

    // R2: B bus is only driven while the A-to-B enable is high
    a_r2_b_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe != '0) |-> ab_en);

    // R3: A bus is only driven while the B-to-A enable is low
    a_r3_a_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe != '0) |-> !ba_en_n);

    // R7: isolation leaves both buses undriven
    a_r7_isolate: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_en && ba_en_n) |-> (a_oe == '0 && b_oe == '0));

    // R4: live single-direction path passes A straight to B
    a_r4_live_b: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_en && ba_en_n && !ab_sel) |-> (b_out == a_in));

    // R5: stored select shows the capture register on the far bus
    a_r5_stored_b: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_en && ab_sel) |-> (b_out == st_ab));

    a_r5_stored_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_en_n && ba_sel) |-> (a_out == st_ba));

    // R10: in the live-live loop each bus repeats the other bus of the prior cycle
    a_r10_loop_b: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_en && !ba_en_n && !ab_sel && !ba_sel) |-> (b_out == hold_a));

endmodule

// File: rtl/xcvr_regbus.sv
module xcvr_regbus #(
    parameter int NUM_HALVES = 2,
    parameter int HALF_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_HALVES-1:0]        ab_en,
    input  logic [NUM_HALVES-1:0]        ba_en_n,
    input  logic [NUM_HALVES-1:0]        ab_cap,
    input  logic [NUM_HALVES-1:0]        ba_cap,
    input  logic [NUM_HALVES-1:0]        ab_sel,
    input  logic [NUM_HALVES-1:0]        ba_sel,
    input  logic [NUM_HALVES*HALF_W-1:0] a_in,
    input  logic [NUM_HALVES*HALF_W-1:0] b_in,
    output logic [NUM_HALVES*HALF_W-1:0] a_out,
    output logic [NUM_HALVES*HALF_W-1:0] b_out,
    output logic [NUM_HALVES*HALF_W-1:0] a_oe,
    output logic [NUM_HALVES*HALF_W-1:0] b_oe
);

    localparam int TOTAL_W = NUM_HALVES * HALF_W;

    logic [TOTAL_W-1:0] a_out_w;
    logic [TOTAL_W-1:0] b_out_w;
    logic [TOTAL_W-1:0] a_oe_w;
    logic [TOTAL_W-1:0] b_oe_w;

    // R11: each half is built from its own slice only
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        xcvr_half #(.HALF_W(HALF_W)) u_half (
            .clk     (clk),
            .rst_n   (rst_n),
            .ab_en   (ab_en[h]),
            .ba_en_n (ba_en_n[h]),
            .ab_cap  (ab_cap[h]),
            .ba_cap  (ba_cap[h]),
            .ab_sel  (ab_sel[h]),
            .ba_sel  (ba_sel[h]),
            .a_in    (a_in[h*HALF_W +: HALF_W]),
            .b_in    (b_in[h*HALF_W +: HALF_W]),
            .a_out   (a_out_w[h*HALF_W +: HALF_W]),
            .b_out   (b_out_w[h*HALF_W +: HALF_W]),
            .a_oe    (a_oe_w[h*HALF_W +: HALF_W]),
            .b_oe    (b_oe_w[h*HALF_W +: HALF_W])
        );
    end

    assign a_out = a_out_w;
    assign b_out = b_out_w;
    assign a_oe  = a_oe_w;
    assign b_oe  = b_oe_w;

endmodule

// File: tb/xcvr_regbus_tb.sv
module xcvr_regbus_tb;

    localparam int NH = 2;
    localparam int HW = 8;
    localparam int TW = NH * HW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NH-1:0] ab_en = '0;
    logic [NH-1:0] ba_en_n = '1;
    logic [NH-1:0] ab_cap = '0;
    logic [NH-1:0] ba_cap = '0;
    logic [NH-1:0] ab_sel = '0;
    logic [NH-1:0] ba_sel = '0;
    logic [TW-1:0] ext_a = '0;
    logic [TW-1:0] ext_b = '0;
    logic [TW-1:0] a_in, b_in, a_out, b_out, a_oe, b_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // outside bus resolution: our driver wins where enabled
    assign a_in = (a_oe & a_out) | (~a_oe & ext_a);
    assign b_in = (b_oe & b_out) | (~b_oe & ext_b);

    xcvr_regbus #(.NUM_HALVES(NH), .HALF_W(HW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ab_en(ab_en), .ba_en_n(ba_en_n),
        .ab_cap(ab_cap), .ba_cap(ba_cap),
        .ab_sel(ab_sel), .ba_sel(ba_sel),
        .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .b_out(b_out),
        .a_oe(a_oe), .b_oe(b_oe)
    );

    typedef struct packed {
        logic       ab_en;
        logic       ba_en_n;
        logic       ab_sel;
        logic       ba_sel;
        logic [7:0] ea;
        logic [7:0] eb;
        logic       x_aoe;
        logic       x_boe;
        logic [7:0] x_a;
        logic [7:0] x_b;
    } vec_t;

    // half 0; registers preloaded with A-to-B = 3C, B-to-A = A5
    localparam vec_t TBL [7] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 1'b0, 8'h00, 8'h00},
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 1'b1, 8'h00, 8'h11},
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'h11, 8'h22, 1'b0, 1'b1, 8'h00, 8'h3C},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 1'b1, 1'b0, 8'h22, 8'h00},
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'h11, 8'h22, 1'b1, 1'b0, 8'hA5, 8'h00},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'h11, 8'h22, 1'b1, 1'b1, 8'hA5, 8'h3C},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'h11, 8'h22, 1'b1, 1'b1, 8'hA5, 8'hA5}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_half(input int h, input logic en, input logic en_n,
                            input logic sa, input logic sb);
        ab_en[h]   = en;
        ba_en_n[h] = en_n;
        ab_sel[h]  = sa;
        ba_sel[h]  = sb;
    endtask

    // strobe held high for 'len' negedge-to-negedge cycles
    task automatic pulse(input int h, input logic do_ab, input logic do_ba, input int len);
        @(negedge clk);
        ab_cap[h] = do_ab;
        ba_cap[h] = do_ba;
        for (int i = 0; i < len; i++) @(negedge clk);
        ab_cap[h] = 1'b0;
        ba_cap[h] = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1, R2, R3: idle state after reset
        settle();
        chk("R2 idle b_oe", b_oe, 16'h0000);
        chk("R3 idle a_oe", a_oe, 16'h0000);
        set_half(0, 1'b1, 1'b0, 1'b1, 1'b1);
        set_half(1, 1'b1, 1'b0, 1'b1, 1'b1);
        settle();
        chk("R1 reset stored b", b_out, 16'h0000);
        chk("R1 reset stored a", a_out, 16'h0000);

        // R7: load both registers in isolation
        set_half(0, 1'b0, 1'b1, 1'b0, 1'b0);
        set_half(1, 1'b0, 1'b1, 1'b0, 1'b0);
        ext_a = 16'h003C;
        ext_b = 16'h00A5;
        settle();
        chk("R7 isolate no drive", a_oe | b_oe, 16'h0000);
        pulse(0, 1'b1, 1'b1, 1);

        // table walk over half 0
        for (int i = 0; i < 7; i++) begin
            set_half(0, TBL[i].ab_en, TBL[i].ba_en_n, TBL[i].ab_sel, TBL[i].ba_sel);
            ext_a[7:0] = TBL[i].ea;
            ext_b[7:0] = TBL[i].eb;
            settle();
            chk("R2 table b_oe", {8'h00, b_oe[7:0]}, {8'h00, {8{TBL[i].x_boe}}});
            chk("R3 table a_oe", {8'h00, a_oe[7:0]}, {8'h00, {8{TBL[i].x_aoe}}});
            if (TBL[i].x_boe) chk("R4 R5 R9 table b", {8'h00, b_out[7:0]}, {8'h00, TBL[i].x_b});
            if (TBL[i].x_aoe) chk("R4 R5 R9 table a", {8'h00, a_out[7:0]}, {8'h00, TBL[i].x_a});
        end

        // R11: half 1 untouched by half 0 activity, still zero stored
        set_half(1, 1'b1, 1'b0, 1'b1, 1'b1);
        settle();
        chk("R11 half1 stored b", {8'h00, b_out[15:8]}, 16'h0000);
        chk("R11 half1 stored a", {8'h00, a_out[15:8]}, 16'h0000);

        // R8: A live to B, both strobes together -> A in both registers
        set_half(0, 1'b1, 1'b1, 1'b0, 1'b0);
        set_half(1, 1'b0, 1'b1, 1'b0, 1'b0);
        ext_a = 16'h995A;
        ext_b = 16'h6677;
        pulse(0, 1'b1, 1'b1, 1);
        set_half(0, 1'b1, 1'b0, 1'b1, 1'b1);
        settle();
        chk("R8 ab reg holds A", {8'h00, b_out[7:0]}, 16'h005A);
        chk("R8 ba reg holds A", {8'h00, a_out[7:0]}, 16'h005A);

        // R6: strobe held high, bus changes, only first value kept
        set_half(0, 1'b0, 1'b1, 1'b0, 1'b0);
        ext_a[7:0] = 8'h77;
        @(negedge clk);
        ab_cap[0] = 1'b1;
        @(negedge clk);
        ext_a[7:0] = 8'h88;
        @(negedge clk);
        @(negedge clk);
        ab_cap[0] = 1'b0;
        set_half(0, 1'b1, 1'b1, 1'b1, 1'b0);
        settle();
        chk("R6 no reload while high", {8'h00, b_out[7:0]}, 16'h0077);

        // R10: live-live loop holds last value after outside driver changes
        set_half(0, 1'b1, 1'b1, 1'b0, 1'b0);
        ext_a[7:0] = 8'hC3;
        settle();
        settle();
        ba_en_n[0] = 1'b0;
        ext_a[7:0] = 8'h00;
        ext_b[7:0] = 8'hFF;
        settle();
        settle();
        settle();
        chk("R10 loop a holds", {8'h00, a_out[7:0]}, 16'h00C3);
        chk("R10 loop b holds", {8'h00, b_out[7:0]}, 16'h00C3);

        // R11: half 1 in B-to-A live while half 0 loops
        set_half(1, 1'b0, 1'b0, 1'b0, 1'b0);
        ext_b[15:8] = 8'h4D;
        settle();
        chk("R11 half1 live a", {8'h00, a_out[15:8]}, 16'h004D);
        chk("R11 half0 unaffected", {8'h00, b_out[7:0]}, 16'h00C3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule